// File: doc/BRIEF.md
# Bank Interleave Address Mapper

This block turns a physical cache-line address into a bank select and a line address inside that bank, for one group of banks that all have the same size. The number of banks in the group need not be a power of two. Consecutive lines rotate across the banks. Each run of N lines, where N is the largest power of two not above the bank count, lands on N different banks. Every bank is filled evenly over the whole group range. No region falls back to a narrower interleave.

The mapping is line index modulo bank count for the bank, and line index divided by bank count for the local line. When the bank count is a power of two, this reduces to taking the low-order address bits. The group geometry comes from two configuration inputs. These are loaded only while a configuration-valid strobe is low and are frozen while it is high, so decode always sees a steady geometry. A request is decoded in one registered stage. An address past the end of the group raises an out-of-range flag and returns bank 0, line 0.

Top module: `ilv_mapper`

## Requirements
- R1: A request presented while `cfg_valid` is high produces `map_valid` high on the following clock cycle. A request presented while `cfg_valid` is low, or no request, produces `map_valid` low on the following cycle.
- R2: For an in-range line address A and bank count B, `map_bank` equals A mod B.
- R3: For an in-range line address A, `map_local` equals A div B (integer quotient).
- R4: When B is a power of two, `map_bank` equals the low log2(B) bits of A.
- R5: For any N consecutive in-range addresses, where N is the largest power of two not above B, the N bank selects are all different.
- R6: Over all in-range addresses of a group, no two addresses yield the same pair of bank and local line.
- R7: An address A with A >= B * S, where S is the bank size in lines, gives `map_oor` = 1, `map_bank` = 0 and `map_local` = 0. A bank count of 0 makes every address out of range.
- R8: The bank count and bank size are captured only on clock edges where `cfg_valid` is low. Changes to `cfg_bank_count` and `cfg_bank_lines` while `cfg_valid` is high have no effect on decode.
- R9: A configured bank count above MAX_BANKS (default 8) is stored as MAX_BANKS.
- R10: After reset, `map_valid`, `map_bank`, `map_local` and `map_oor` are 0, and the stored bank count and size are 0, so every address decodes out of range.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cfg_valid | input | 1 | Low: geometry inputs are loaded; high: geometry held, decode enabled |
| cfg_bank_count | input | CNT_W (4) | Number of banks in the group |
| cfg_bank_lines | input | SIZE_W (16) | Lines per bank |
| req_valid | input | 1 | Request strobe |
| req_line | input | ADDR_W (16) | Cache-line address to decode |
| map_valid | output | 1 | Decode result valid |
| map_bank | output | BIDX_W (3) | Selected bank |
| map_local | output | SIZE_W (16) | Line address inside the bank |
| map_oor | output | 1 | Address beyond the group |

## Verification
The properties assume that geometry changes happen only with `cfg_valid` low. They also assume that decode results are read only while `cfg_valid` stays high, so the stored count and size match what the result was computed from. The stimulus follows this order: it loads a geometry with the strobe low, raises the strobe for at least one edge, and only then issues requests. It changes the geometry inputs under a high strobe only to show that they are ignored. Exhaustive sweeps cover bank counts 1 to 8 with a bank size of five lines, so uneven counts and an uneven size are both exercised.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Default geometry of one interleave group.
  localparam int unsigned ILV_ADDR_W_DEF    = 16;
  localparam int unsigned ILV_SIZE_W_DEF    = 16;
  localparam int unsigned ILV_MAX_BANKS_DEF = 8;
endpackage

// File: rtl/ilv_cfg_hold.sv
module ilv_cfg_hold #(
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned SIZE_W    = 16,
  parameter int unsigned MAX_BANKS = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [CNT_W-1:0]  cnt_in,
  input  logic [SIZE_W-1:0] size_in,
  output logic [CNT_W-1:0]  cnt_q,
  output logic [SIZE_W-1:0] size_q
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_BANKS);

  logic [CNT_W-1:0]  cnt_nxt;
  logic [SIZE_W-1:0] size_nxt;
  logic              load_en;

  // Next-state: clamp the bank count (R9)
  always_comb begin
    load_en  = !cfg_valid;
    cnt_nxt  = (cnt_in > CNT_MAX) ? CNT_MAX : cnt_in;
    size_nxt = size_in;
  end

  // Register: loads only while the strobe is low (R8)
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      size_q <= '0;
    end else if (load_en) begin
      cnt_q  <= cnt_nxt;
      size_q <= size_nxt;
    end
  end
endmodule

// File: rtl/ilv_divmod.sv
module ilv_divmod #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned CNT_W  = 4
) (
  input  logic [ADDR_W-1:0] dividend,
  input  logic [CNT_W-1:0]  divisor,   // caller guarantees nonzero
  output logic [ADDR_W-1:0] quot,
  output logic [CNT_W-1:0]  rem
);
  // Partial remainder entering each restoring stage; stage ADDR_W is the seed.
  logic [ADDR_W:0][CNT_W:0] part;

  assign part[ADDR_W] = '0;

  for (genvar i = ADDR_W - 1; i >= 0; i--) begin : g_stage
    logic [CNT_W:0] trial;
    logic           ge;
    assign trial   = {part[i+1][CNT_W-1:0], dividend[i]};
    assign ge      = (trial >= {1'b0, divisor});
    assign part[i] = ge ? (trial - {1'b0, divisor}) : trial;
    assign quot[i] = ge;
  end

  assign rem = part[0][CNT_W-1:0];
endmodule

// File: rtl/ilv_mapper.sv
module ilv_mapper #(
  parameter int unsigned ADDR_W    = ilv_pkg::ILV_ADDR_W_DEF,
  parameter int unsigned SIZE_W    = ilv_pkg::ILV_SIZE_W_DEF,
  parameter int unsigned MAX_BANKS = ilv_pkg::ILV_MAX_BANKS_DEF,
  localparam int unsigned CNT_W    = $clog2(MAX_BANKS + 1),
  localparam int unsigned BIDX_W   = $clog2(MAX_BANKS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_valid,
  input  logic [CNT_W-1:0]  cfg_bank_count,
  input  logic [SIZE_W-1:0] cfg_bank_lines,
  input  logic              req_valid,
  input  logic [ADDR_W-1:0] req_line,
  output logic              map_valid,
  output logic [BIDX_W-1:0] map_bank,
  output logic [SIZE_W-1:0] map_local,
  output logic              map_oor
);
  localparam int unsigned LIM_W = CNT_W + SIZE_W;
  localparam int unsigned CMP_W = (LIM_W > ADDR_W) ? LIM_W : ADDR_W;

  // Reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= 2'b00;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_n_s = rst_pipe[1];

  // Group geometry
  logic [CNT_W-1:0]  cnt_q;
  logic [SIZE_W-1:0] size_q;

  ilv_cfg_hold #(
    .CNT_W(CNT_W), .SIZE_W(SIZE_W), .MAX_BANKS(MAX_BANKS)
  ) u_cfg (
    .clk(clk), .rst_n(rst_n_s), .cfg_valid(cfg_valid),
    .cnt_in(cfg_bank_count), .size_in(cfg_bank_lines),
    .cnt_q(cnt_q), .size_q(size_q)
  );

  // Bank = line mod count, local = line div count
  logic [CNT_W-1:0]  divisor;
  logic [ADDR_W-1:0] quot;
  logic [CNT_W-1:0]  rem;

  assign divisor = (cnt_q == '0) ? CNT_W'(1) : cnt_q;

  ilv_divmod #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_div (
    .dividend(req_line), .divisor(divisor), .quot(quot), .rem(rem)
  );

  // Range check and next-state of the result stage
  logic [LIM_W-1:0]  limit;
  logic              oor_c;
  logic              dec_en;
  logic              valid_nxt;
  logic [BIDX_W-1:0] bank_nxt;
  logic [SIZE_W-1:0] local_nxt;

  always_comb begin
    limit     = LIM_W'(cnt_q) * LIM_W'(size_q);
    oor_c     = (CMP_W'(req_line) >= CMP_W'(limit));
    dec_en    = req_valid && cfg_valid;
    valid_nxt = dec_en;
    bank_nxt  = oor_c ? '0 : rem[BIDX_W-1:0];
    local_nxt = oor_c ? '0 : SIZE_W'(quot);
  end

  always_ff @(posedge clk or negedge rst_n_s) begin
    if (!rst_n_s) begin
      map_valid <= 1'b0;
      map_bank  <= '0;
      map_local <= '0;
      map_oor   <= 1'b0;
    end else begin
      map_valid <= valid_nxt;
      if (dec_en) begin
        map_bank  <= bank_nxt;
        map_local <= local_nxt;
        map_oor   <= oor_c;
      end
    end
  end
endmodule

// File: rtl/ilv_mapper_chk.sv
module ilv_mapper_chk #(
  parameter int unsigned ADDR_W    = 16,
  parameter int unsigned SIZE_W    = 16,
  parameter int unsigned MAX_BANKS = 8,
  parameter int unsigned CNT_W     = 4,
  parameter int unsigned BIDX_W    = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cfg_valid,
  input logic              req_valid,
  input logic [ADDR_W-1:0] req_line,
  input logic [CNT_W-1:0]  cnt_q,
  input logic [SIZE_W-1:0] size_q,
  input logic              map_valid,
  input logic [BIDX_W-1:0] map_bank,
  input logic [SIZE_W-1:0] map_local,
  input logic              map_oor
);
  p_valid_next_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cfg_valid) |=> map_valid);

  p_valid_drop_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !(req_valid && cfg_valid) |=> !map_valid);

  p_bank_below_count_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && !map_oor) |-> (CNT_W'(map_bank) < cnt_q));

  p_local_below_size_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && !map_oor) |-> (map_local < size_q));

  p_pow2_low_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && !map_oor && ($countones(cnt_q) == 1)) |->
      (map_bank == ($past(req_line[BIDX_W-1:0]) & BIDX_W'(cnt_q - 1'b1))));

  p_oor_zeroed_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (map_valid && map_oor) |-> ((map_bank == '0) && (map_local == '0)));

  p_cfg_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_valid |=> ($stable(cnt_q) && $stable(size_q)));

  p_count_clamped_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(MAX_BANKS));
endmodule

bind ilv_mapper ilv_mapper_chk #(
  .ADDR_W(ADDR_W), .SIZE_W(SIZE_W), .MAX_BANKS(MAX_BANKS),
  .CNT_W(CNT_W), .BIDX_W(BIDX_W)
) u_chk (
  .clk(clk), .rst_n(rst_n_s), .cfg_valid(cfg_valid),
  .req_valid(req_valid), .req_line(req_line),
  .cnt_q(cnt_q), .size_q(size_q),
  .map_valid(map_valid), .map_bank(map_bank),
  .map_local(map_local), .map_oor(map_oor)
);

// File: tb/tb_ilv_mapper.sv
module tb_ilv_mapper;
  localparam int CLK_PERIOD = 10;
  localparam int ADDR_W = 16;
  localparam int SIZE_W = 16;
  localparam int CNT_W  = 4;
  localparam int BIDX_W = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              cfg_valid;
  logic [CNT_W-1:0]  cfg_bank_count;
  logic [SIZE_W-1:0] cfg_bank_lines;
  logic              req_valid;
  logic [ADDR_W-1:0] req_line;
  logic              map_valid;
  logic [BIDX_W-1:0] map_bank;
  logic [SIZE_W-1:0] map_local;
  logic              map_oor;

  int n_checks = 0;
  int n_fail   = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ilv_mapper dut (
    .clk(clk), .rst_n(rst_n), .cfg_valid(cfg_valid),
    .cfg_bank_count(cfg_bank_count), .cfg_bank_lines(cfg_bank_lines),
    .req_valid(req_valid), .req_line(req_line),
    .map_valid(map_valid), .map_bank(map_bank),
    .map_local(map_local), .map_oor(map_oor)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic load_cfg(input int cnt, input int lines);
    @(negedge clk);
    cfg_valid      = 1'b0;
    cfg_bank_count = CNT_W'(cnt);
    cfg_bank_lines = SIZE_W'(lines);
    @(negedge clk);
    cfg_valid = 1'b1;
    @(negedge clk);
  endtask

  task automatic decode(input int a, output int bk, output int lc, output bit oo, output bit vl);
    @(negedge clk);
    req_line  = ADDR_W'(a);
    req_valid = 1'b1;
    @(negedge clk);
    bk = int'(map_bank); lc = int'(map_local); oo = map_oor; vl = map_valid;
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    int bk, lc; bit oo, vl;
    rst_n = 1'b0; cfg_valid = 1'b1; cfg_bank_count = '0; cfg_bank_lines = '0;
    req_valid = 1'b0; req_line = '0;
    repeat (3) @(negedge clk);
    check(map_valid == 1'b0, "R10 valid", int'(map_valid), 0);
    check(map_bank == '0 && map_local == '0, "R10 bank/local", int'(map_bank) + int'(map_local), 0);
    check(map_oor == 1'b0, "R10 oor", int'(map_oor), 0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    decode(0, bk, lc, oo, vl);
    check(vl == 1'b1, "R1 valid after request", int'(vl), 1);
    check(oo == 1'b1, "R10 cleared geometry is out of range", int'(oo), 1);
  endtask

  task automatic t_sweep(input int b, input int s);
    int bk, lc, n, total; bit oo, vl;
    bit seen [0:7][0:7];
    int banks [0:63];
    bit dup, clash;
    total = b * s;
    n = 1;
    while (n * 2 <= b) n = n * 2;
    for (int i = 0; i < 8; i++) for (int j = 0; j < 8; j++) seen[i][j] = 1'b0;
    load_cfg(b, s);
    for (int a = 0; a < total; a++) begin
      decode(a, bk, lc, oo, vl);
      check(vl && !oo && bk == a % b, "R2 bank is line mod count", bk, a % b);
      check(lc == a / b, "R3 local is line div count", lc, a / b);
      clash = (bk > 7 || lc > 7) ? 1'b1 : seen[bk][lc];
      check(!clash, "R6 pair used once", bk * 8 + lc, -1);
      if (bk <= 7 && lc <= 7) seen[bk][lc] = 1'b1;
      banks[a] = bk;
    end
    for (int a = 0; a + n <= total; a++) begin
      dup = 1'b0;
      for (int i = 0; i < n; i++)
        for (int j = i + 1; j < n; j++)
          if (banks[a+i] == banks[a+j]) dup = 1'b1;
      check(!dup, "R5 run of N lines on distinct banks", a, n);
    end
  endtask

  task automatic t_pow2();
    int bk, lc; bit oo, vl;
    load_cfg(4, 1000);
    decode(3999, bk, lc, oo, vl);
    check(!oo && bk == (3999 & 3), "R4 low bits, count 4", bk, 3999 & 3);
    decode(1234, bk, lc, oo, vl);
    check(!oo && bk == (1234 & 3), "R4 low bits, count 4", bk, 1234 & 3);
    check(lc == 1234 / 4, "R3 local, count 4", lc, 1234 / 4);
  endtask

  task automatic t_oor();
    int bk, lc; bit oo, vl;
    load_cfg(6, 5);
    decode(29, bk, lc, oo, vl);
    check(oo == 1'b0 && bk == 5 && lc == 4, "R7 last line in range", bk * 100 + lc, 504);
    decode(30, bk, lc, oo, vl);
    check(oo == 1'b1 && bk == 0 && lc == 0, "R7 first line past end", int'(oo), 1);
    decode(65535, bk, lc, oo, vl);
    check(oo == 1'b1 && bk == 0 && lc == 0, "R7 top address", int'(oo), 1);
    load_cfg(0, 5);
    decode(0, bk, lc, oo, vl);
    check(oo == 1'b1, "R7 zero banks", int'(oo), 1);
  endtask

  task automatic t_hold();
    int bk, lc; bit oo, vl;
    load_cfg(6, 5);
    @(negedge clk);
    cfg_bank_count = CNT_W'(3);
    cfg_bank_lines = SIZE_W'(2);
    repeat (2) @(negedge clk);
    decode(29, bk, lc, oo, vl);
    check(!oo && bk == 5, "R8 count held under high strobe", bk, 5);
    check(lc == 4, "R8 size held under high strobe", lc, 4);
    @(negedge clk);
    cfg_valid = 1'b0; req_valid = 1'b1; req_line = ADDR_W'(1);
    @(negedge clk);
    check(map_valid == 1'b0, "R1 no result while strobe low", int'(map_valid), 0);
    req_valid = 1'b0;
    cfg_valid = 1'b1;
  endtask

  task automatic t_clamp();
    int bk, lc; bit oo, vl;
    load_cfg(15, 5);
    decode(13, bk, lc, oo, vl);
    check(!oo && bk == 5 && lc == 1, "R9 count clamped to 8", bk * 100 + lc, 501);
    decode(39, bk, lc, oo, vl);
    check(oo == 1'b0 && bk == 7, "R9 last line of 8 banks", bk, 7);
    decode(40, bk, lc, oo, vl);
    check(oo == 1'b1, "R9 range uses clamped count", int'(oo), 1);
  endtask

  initial begin
    t_reset();
    for (int b = 1; b <= 8; b++) t_sweep(b, 5);
    t_pow2();
    t_oor();
    t_hold();
    t_clamp();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_checks++;
      n_fail++;
      $display("FAIL watchdog: actual %0d expected %0d", 150000, 0);
      $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule